// File: doc/BRIEF.md
# SPI Port Interrupt Request Generator

This block merges every condition that should interrupt the processor on behalf of one SPI port into a single latched request line. The port runs either under core control, where the processor moves each word itself, or under DMA control. In core mode a transfer-mode field picks which buffer status drives the request: receive-buffer-full or transmit-buffer-empty. In DMA mode the request reports transfer completion and DMA errors. It can be turned off as a whole with a DMA-interrupt enable.

For DMA completion there are three choices. The request can fire when the internal word count empties, or only once the final word has been shifted out on the pins, as chosen by an end-of-transfer select bit. With chaining enabled, it fires only when the whole chained sequence completes. A multimaster error and an underflow or overflow error raise the same request whatever the completion setting. Every cause sets a sticky bit in a five-bit cause status. The request line and the status both hold until the processor pulses an acknowledge. All inputs are synchronous to the peripheral clock. Each source acts on its rising edge, so a flag that stays high raises the request only once.

Top module: `spi_irq_gen`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0 and `cause` is 00000. Cause bit positions: bit 0 DMA done, bit 1 RX full, bit 2 TX empty, bit 3 multimaster error, bit 4 underflow/overflow error.
- R2: With `dma_mode`=0 and `xfer_mode`=00, a rising edge of `rx_full` sampled at a clock edge makes `irq` 1 and sets `cause` bit 1 right after that same edge. `tx_empty` has no effect.
- R3: With `dma_mode`=0 and `xfer_mode` not 00, a rising edge of `tx_empty` sets `irq` and `cause` bit 2 one clock later. `rx_full` has no effect.
- R4: With `dma_mode`=1, `dma_irq_en`=1, `chain_en`=0 and `eot_ext`=0, a rising edge of `cnt_zero` sets `cause` bit 0 and `irq`. `shift_done` has no effect.
- R5: With `dma_mode`=1, `dma_irq_en`=1, `chain_en`=0 and `eot_ext`=1, a rising edge of `shift_done` sets `cause` bit 0. `cnt_zero` has no effect.
- R6: With `dma_mode`=1, `dma_irq_en`=1 and `chain_en`=1, only a rising edge of `chain_done` sets `cause` bit 0. `cnt_zero` and `shift_done` have no effect.
- R7: With `dma_mode`=1 and `dma_irq_en`=1, a rising edge of `err_mm` sets `cause` bit 3, and a rising edge of `err_urun` or `err_orun` sets `cause` bit 4, whatever the values of `eot_ext` and `chain_en`.
- R8: With `dma_mode`=1 and `dma_irq_en`=0, no input changes `irq` or `cause`.
- R9: Core-mode sources are ignored in DMA mode, and DMA sources are ignored in core mode.
- R10: Once set, `irq` stays 1 and `cause` bits accumulate until `ack` is sampled high.
- R11: `ack` clears `irq` and `cause` one clock later. If a new cause arrives in the same cycle as `ack`, `irq` stays 1 and `cause` holds only the new cause.
- R12: Sources act on rising edges only, so an input held high raises at most one event until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_mode | input | 1 | 1 = DMA control, 0 = core control |
| xfer_mode | input | 2 | Transfer-mode field; 00 = receive-driven |
| eot_ext | input | 1 | End-of-transfer select: 1 = after last word leaves the pins |
| chain_en | input | 1 | DMA chaining enabled |
| dma_irq_en | input | 1 | DMA interrupt enable |
| rx_full | input | 1 | Receive buffer full |
| tx_empty | input | 1 | Transmit buffer empty |
| cnt_zero | input | 1 | DMA word count reached zero |
| shift_done | input | 1 | Last word shifted out externally |
| chain_done | input | 1 | Chained DMA sequence complete |
| err_mm | input | 1 | DMA multimaster error |
| err_urun | input | 1 | DMA underflow error |
| err_orun | input | 1 | DMA overflow error |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Latched interrupt request |
| cause | output | 5 | Sticky per-cause status |

## Verification
A stuck or stale edge-detect register appears at the ports on the next clock edge. The request is then either missed after a rising source, or repeated while a source is held high. A wrong mode decode shows up one cycle after the offending event, as an extra or missing `cause` bit. A latch fault shows as `irq` and the OR of `cause` disagreeing, or as either one failing to clear one cycle after `ack`. Because a reference model is compared every cycle, any such divergence is reported in the cycle it appears.

// File: rtl/spi_irq_pkg.sv
// Shared constants and types for the SPI interrupt request generator.
// Assumes: source and cause index maps below are fixed by the top-level wiring.
package spi_irq_pkg;
    localparam int NUM_SRC   = 8;
    localparam int NUM_CAUSE = 5;

    // source vector positions
    localparam int S_RXF  = 0;
    localparam int S_TXE  = 1;
    localparam int S_CNTZ = 2;
    localparam int S_SHDN = 3;
    localparam int S_CHDN = 4;
    localparam int S_MM   = 5;
    localparam int S_UR   = 6;
    localparam int S_OR   = 7;

    // cause status positions
    localparam int C_DONE = 0;
    localparam int C_RXF  = 1;
    localparam int C_TXE  = 2;
    localparam int C_MM   = 3;
    localparam int C_UOF  = 4;

    typedef struct packed {
        logic       dma_mode;
        logic [1:0] xfer_mode;
        logic       eot_ext;
        logic       chain_en;
        logic       dma_irq_en;
    } irq_cfg_t;
endpackage

// File: rtl/spi_irq_edge.sv
// Rising-edge detector bank, one flop per source.
// Assumes: inputs are synchronous to clk; history clears to 0 on reset,
// so a source already high after reset counts as one rising edge.
module spi_irq_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Remember last sampled level of source i.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

    // R12
    held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[0] && $past(lvl[0])) |-> !rise[0]);
endmodule

// File: rtl/spi_irq_qual.sv
// Mode qualifier: maps source rising edges onto cause hits according to
// core/DMA mode, transfer-mode field, end-of-transfer select, chaining and
// the DMA interrupt enable. Pure combinational; clk/rst_n serve the checks.
module spi_irq_qual
    import spi_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  irq_cfg_t             cfg,
    input  logic [NUM_SRC-1:0]   rise,
    output logic [NUM_CAUSE-1:0] hit
);
    logic done_evt;

    // Pick the DMA completion event for the configured end-of-transfer rule.
    always_comb begin
        if (cfg.chain_en)     done_evt = rise[S_CHDN];
        else if (cfg.eot_ext) done_evt = rise[S_SHDN];
        else                  done_evt = rise[S_CNTZ];
    end

    // Route edges into causes; the mode picks the core or the DMA group.
    always_comb begin
        hit = '0;
        if (!cfg.dma_mode) begin
            if (cfg.xfer_mode == 2'b00) hit[C_RXF] = rise[S_RXF];
            else                        hit[C_TXE] = rise[S_TXE];
        end else if (cfg.dma_irq_en) begin
            hit[C_DONE] = done_evt;
            hit[C_MM]   = rise[S_MM];
            hit[C_UOF]  = rise[S_UR] | rise[S_OR];
        end
    end

    // R9
    core_blocks_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.dma_mode |-> (hit[C_DONE] == 1'b0 && hit[C_MM] == 1'b0 && hit[C_UOF] == 1'b0));
    // R9
    dma_blocks_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.dma_mode |-> (hit[C_RXF] == 1'b0 && hit[C_TXE] == 1'b0));
    // R8
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.dma_mode && !cfg.dma_irq_en) |-> hit == '0);
    // R6
    chain_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.dma_mode && cfg.chain_en && !rise[S_CHDN]) |-> !hit[C_DONE]);
endmodule

// File: rtl/spi_irq_latch.sv
// Request latch and sticky cause status. An acknowledge clears both, but a
// cause arriving in the acknowledge cycle survives it.
// Assumes: ack is a synchronous pulse; hit is already mode-qualified.
module spi_irq_latch #(
    parameter int NC = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NC-1:0] hit,
    input  logic          ack,
    output logic          irq,
    output logic [NC-1:0] cause
);
    logic any_hit;
    assign any_hit = |hit;

    // Sticky cause bits: accumulate, or restart from this cycle's hits on ack.
    always_ff @(posedge clk) begin
        if (!rst_n)   cause <= '0;
        else if (ack) cause <= hit;
        else          cause <= cause | hit;
    end

    // Request line: set by any hit, held until ack without a coincident hit.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq <= 1'b0;
        else if (ack) irq <= any_hit;
        else if (any_hit) irq <= 1'b1;
    end

    // R2
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> irq);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && ((cause & $past(cause)) == $past(cause))));
    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !any_hit) |=> (!irq && cause == '0));
    // R11
    line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (cause != '0));
endmodule

// File: rtl/spi_irq_gen.sv
// Top: SPI interrupt request generator. Gathers core buffer flags, DMA
// completion events and DMA errors, detects their rising edges, qualifies
// them by mode and latches one request plus a sticky cause status.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module spi_irq_gen
    import spi_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dma_mode,
    input  logic [1:0] xfer_mode,
    input  logic       eot_ext,
    input  logic       chain_en,
    input  logic       dma_irq_en,
    input  logic       rx_full,
    input  logic       tx_empty,
    input  logic       cnt_zero,
    input  logic       shift_done,
    input  logic       chain_done,
    input  logic       err_mm,
    input  logic       err_urun,
    input  logic       err_orun,
    input  logic       ack,
    output logic       irq,
    output logic [4:0] cause
);
    logic [NUM_SRC-1:0]   src_lvl;
    logic [NUM_SRC-1:0]   src_rise;
    logic [NUM_CAUSE-1:0] hit;
    irq_cfg_t             cfg;

    // Pack sources and configuration into the shared layouts.
    always_comb begin
        src_lvl         = '0;
        src_lvl[S_RXF]  = rx_full;
        src_lvl[S_TXE]  = tx_empty;
        src_lvl[S_CNTZ] = cnt_zero;
        src_lvl[S_SHDN] = shift_done;
        src_lvl[S_CHDN] = chain_done;
        src_lvl[S_MM]   = err_mm;
        src_lvl[S_UR]   = err_urun;
        src_lvl[S_OR]   = err_orun;
        cfg.dma_mode    = dma_mode;
        cfg.xfer_mode   = xfer_mode;
        cfg.eot_ext     = eot_ext;
        cfg.chain_en    = chain_en;
        cfg.dma_irq_en  = dma_irq_en;
    end

    spi_irq_edge #(.W(NUM_SRC)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .rise(src_rise)
    );

    spi_irq_qual u_qual (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .rise(src_rise), .hit(hit)
    );

    spi_irq_latch #(.NC(NUM_CAUSE)) u_latch (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack(ack),
        .irq(irq), .cause(cause)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && cause == '0));
endmodule

// File: tb/spi_irq_gen_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus, every cycle
// compared against a requirement-level reference model.
module spi_irq_gen_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n, dma_mode, eot_ext, chain_en, dma_irq_en, ack;
    logic [1:0] xfer_mode;
    logic [7:0] s;           // 0 rx_full,1 tx_empty,2 cnt_zero,3 shift_done,4 chain_done,5 mm,6 urun,7 orun
    logic       irq;
    logic [4:0] cause;

    spi_irq_gen dut_i (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .xfer_mode(xfer_mode),
        .eot_ext(eot_ext), .chain_en(chain_en), .dma_irq_en(dma_irq_en),
        .rx_full(s[0]), .tx_empty(s[1]), .cnt_zero(s[2]), .shift_done(s[3]),
        .chain_done(s[4]), .err_mm(s[5]), .err_urun(s[6]), .err_orun(s[7]),
        .ack(ack), .irq(irq), .cause(cause)
    );

    int n_chk = 0, n_bad = 0;
    string cur = "R1";
    logic [7:0] m_prev = 8'h00;
    logic       m_irq = 1'b0;
    logic [4:0] m_cause = 5'h00;
    bit finished = 0;

    // Cause hits the requirements call for, from levels and previous levels.
    function automatic logic [4:0] exp_hit(input logic [7:0] lv, input logic [7:0] pv);
        logic [7:0] r;
        logic [4:0] h;
        r = lv & ~pv;
        h = '0;
        if (!dma_mode) begin
            if (xfer_mode == 2'b00) h[1] = r[0];
            else                    h[2] = r[1];
        end else if (dma_irq_en) begin
            h[0] = chain_en ? r[4] : (eot_ext ? r[3] : r[2]);
            h[3] = r[5];
            h[4] = r[6] | r[7];
        end
        return h;
    endfunction

    task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {irq,cause} got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // One clock: advance the model with current inputs, compare at negedge.
    task automatic step();
        logic [4:0] h;
        h = exp_hit(s, m_prev);
        @(posedge clk);
        m_prev  = s;
        m_irq   = ack ? (|h) : (m_irq | (|h));
        m_cause = ack ? h : (m_cause | h);
        @(negedge clk);
        chk(cur, {irq, cause}, {m_irq, m_cause});
    endtask

    task automatic pulse(input int idx);
        s[idx] = 1'b1; step(); s[idx] = 1'b0; step();
    endtask

    task automatic do_ack();
        ack = 1'b1; step(); ack = 1'b0;
    endtask

    task automatic setcfg(input logic dm, input logic [1:0] xm, input logic eo,
                          input logic ch, input logic en);
        dma_mode = dm; xfer_mode = xm; eot_ext = eo; chain_en = ch; dma_irq_en = en;
    endtask

    initial begin : watchdog
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        rst_n = 1'b0; ack = 1'b0; s = '0;
        setcfg(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {irq, cause}, 6'b0_00000);
        rst_n = 1'b1;
        step();

        // R2 receive-driven core mode; tx ignored
        cur = "R2";
        s[1] = 1'b1; step(); s[1] = 1'b0; step();
        chk("R2 tx ignored", {irq, cause}, 6'b0_00000);
        s[0] = 1'b1; step();
        chk("R2", {irq, cause}, 6'b1_00010);
        s[0] = 1'b0; step(); do_ack(); step();

        // R3 transmit-driven core mode; rx ignored
        cur = "R3";
        setcfg(1'b0, 2'b01, 1'b0, 1'b0, 1'b0);
        pulse(0);
        chk("R3 rx ignored", {irq, cause}, 6'b0_00000);
        pulse(1);
        chk("R3", {irq, cause}, 6'b1_00100);
        do_ack(); step();

        // R4 internal completion
        cur = "R4";
        setcfg(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
        pulse(3);
        chk("R4 shift ignored", {irq, cause}, 6'b0_00000);
        pulse(2);
        chk("R4", {irq, cause}, 6'b1_00001);
        do_ack(); step();

        // R5 external completion
        cur = "R5";
        eot_ext = 1'b1;
        pulse(2);
        chk("R5 count ignored", {irq, cause}, 6'b0_00000);
        pulse(3);
        chk("R5", {irq, cause}, 6'b1_00001);
        do_ack(); step();

        // R6 chained completion
        cur = "R6";
        chain_en = 1'b1;
        pulse(2); pulse(3);
        chk("R6 segment ignored", {irq, cause}, 6'b0_00000);
        pulse(4);
        chk("R6", {irq, cause}, 6'b1_00001);
        do_ack(); step();

        // R7 errors regardless of completion setting; R10 accumulation
        cur = "R7";
        pulse(5);
        chk("R7 mm", {irq, cause}, 6'b1_01000);
        pulse(7);
        chk("R7/R10 orun accumulates", {irq, cause}, 6'b1_11000);
        do_ack(); step();
        eot_ext = 1'b0; chain_en = 1'b0;
        pulse(6);
        chk("R7 urun", {irq, cause}, 6'b1_10000);
        repeat (4) step();
        chk("R10 held", {irq, cause}, 6'b1_10000);
        do_ack(); step();

        // R8 DMA interrupt enable clear
        cur = "R8";
        dma_irq_en = 1'b0;
        for (int i = 2; i < 8; i++) pulse(i);
        chk("R8", {irq, cause}, 6'b0_00000);

        // R9 core sources in DMA mode
        cur = "R9";
        dma_irq_en = 1'b1;
        pulse(0); xfer_mode = 2'b10; pulse(1);
        chk("R9 core in dma", {irq, cause}, 6'b0_00000);
        setcfg(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        pulse(2); pulse(5); pulse(6);
        chk("R9 dma in core", {irq, cause}, 6'b0_00000);

        // R11 ack with coincident new cause
        cur = "R11";
        pulse(0);
        chk("R11 pre", {irq, cause}, 6'b1_00010);
        xfer_mode = 2'b01; s[1] = 1'b1; ack = 1'b1; step(); ack = 1'b0;
        chk("R11 coincident", {irq, cause}, 6'b1_00100);
        s[1] = 1'b0; do_ack();
        chk("R11 clear", {irq, cause}, 6'b0_00000);

        // R12 held-high source fires once
        cur = "R12";
        s[1] = 1'b1; step(); step();
        do_ack(); step(); step();
        chk("R12 held high", {irq, cause}, 6'b0_00000);
        s[1] = 1'b0; step(); s[1] = 1'b1; step();
        chk("R12 re-rise", {irq, cause}, 6'b1_00100);
        s[1] = 1'b0; do_ack();

        // Random mix across all requirements (R10 sticky/ack interplay)
        cur = "R10 random";
        seed = $urandom(32'h5A1C);
        for (int n = 0; n < 4000; n++) begin
            if (($urandom % 64) == 0)
                setcfg($urandom % 2, $urandom % 4, $urandom % 2, $urandom % 2, ($urandom % 4) != 0);
            for (int b = 0; b < 8; b++)
                if (($urandom % 6) == 0) s[b] = ~s[b];
            ack = (($urandom % 8) == 0);
            step();
        end
        ack = 1'b0;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule